// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches page-table entries so that a virtual address can be turned into a physical address within the cycle it is presented. Each stored entry pairs a virtual page number with a physical page number, three permission bits (read, write, execute) and two caching attributes (cacheable, write-through). A lookup compares the virtual page number against every stored entry at once. On a match it returns the physical address, the caching attributes and a fault flag that says whether the requested kind of access is allowed. When nothing matches, the lookup reports a miss.

A page-table walker outside the block resolves misses by installing entries through a single-cycle fill port. A fill first reuses a slot that already holds the same virtual page. Failing that, it takes the lowest-numbered empty slot, and once every slot is valid it replaces the slot named by a round-robin pointer. A flush input empties the whole buffer in one clock edge. The 12-bit page offset is never translated.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is invalid and every lookup misses.
- R2: A lookup whose virtual page number matches a valid slot returns lk_hit=1 in the same cycle, with lk_paddr equal to the slot's physical page number joined to bits [11:0] of lk_vaddr.
- R3: A lookup that matches no valid slot returns lk_hit=0 and lk_fault=0, and drives lk_paddr, lk_cacheable and lk_wthru to 0.
- R4: lk_acc encodes the access as 0=read, 1=write, 2=execute. On a hit, lk_fault=1 exactly when the slot's matching permission bit is clear, and code 3 always faults. The address and attributes are still reported on a faulting hit.
- R5: On a hit, lk_cacheable and lk_wthru carry the slot's cacheable and write-through bits.
- R6: A fill with fill_present=0 changes no slot.
- R7: A fill for a new page, with an empty slot available, writes the lowest-numbered empty slot. The entry is visible to lookups from the next cycle.
- R8: With every slot valid, a fill for a new page replaces the slot named by a pointer. The pointer is 0 after reset or flush and advances by one, wrapping, after each such replacement.
- R9: A fill whose virtual page number is already held by a valid slot rewrites that slot in place and leaves the pointer unchanged.
- R10: flush invalidates every slot at the next edge. A hit is suppressed in the cycle flush is high, and a fill presented in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | A valid slot matched |
| lk_fault | output | 1 | Hit, but the access is not permitted |
| lk_paddr | output | PA_W | Translated physical address |
| lk_cacheable | output | 1 | Matched page is cacheable |
| lk_wthru | output | 1 | Matched page is write-through (0 = write-back) |
| fill_en | input | 1 | Install an entry this cycle |
| fill_vpn | input | VA_W-12 | Virtual page number to install |
| fill_ppn | input | PA_W-12 | Physical page number to install |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_ex | input | 1 | Execute permitted |
| fill_cache | input | 1 | Cacheable attribute |
| fill_wt | input | 1 | Write-through attribute |
| fill_present | input | 1 | Page is resident in memory; fill dropped when 0 |
| flush | input | 1 | Invalidate all slots |

## Verification
The hardest state to reach is the replacement pointer, because the ports never show it and it only moves once every slot is valid. The stimulus flushes the buffer, which zeroes the pointer, and fills all sixteen slots with distinct pages. It then installs further new pages one at a time, probing after each fill which old page has gone missing and which neighbour still hits. A refill of a page that is already held is placed between two replacements, so any pointer movement it caused would show up as the wrong page being evicted next.

// File: rtl/tlb_pkg.sv
// Shared types for the translation buffer.
// Assumes the access code is two bits wide and the attribute set is fixed.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic cache;
        logic wt;
    } page_attr_t;

endpackage

// File: rtl/tlb_cam.sv
// Entry storage with parallel match for lookup and fill.
// Assumes at most one valid slot holds a given page (kept so by the fill logic),
// so the read mux may OR the one-hot selected slots together.
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  page_attr_t         wr_attr,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] valid,
    output logic [ENTRIES-1:0] fill_match,
    output logic               lk_any,
    output logic [PPN_W-1:0]   lk_ppn,
    output page_attr_t         lk_attr
);
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    page_attr_t         attr_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Slot register: cleared by reset or flush, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid[g]  <= 1'b1;
                vpn_q[g]  <= wr_vpn;
                ppn_q[g]  <= wr_ppn;
                attr_q[g] <= wr_attr;
            end
        end
        // Per-slot comparators for the lookup and the fill ports.
        assign lk_match[g]   = valid[g] && (vpn_q[g] == lk_vpn);
        assign fill_match[g] = valid[g] && (vpn_q[g] == wr_vpn);
    end

    // One-hot read mux: OR together the fields of the matching slot.
    always_comb begin
        lk_ppn  = '0;
        lk_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_ppn  = lk_ppn | ppn_q[i];
                lk_attr = lk_attr | attr_q[i];
            end
        end
    end

    assign lk_any = |lk_match;
endmodule

// File: rtl/tlb_victim.sv
// Picks the slot a fill writes: the slot already holding the page, else the
// lowest empty slot, else the round-robin pointer.
// Assumes fill_match is at most one-hot.
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] fill_match,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic             use_ptr;

    // Encode the matching slot and the lowest-numbered empty slot.
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (fill_match[i]) hit_idx = IDX_W'(i);
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    assign use_ptr = !(|fill_match) && !free_any;
    assign idx     = (|fill_match) ? hit_idx : (free_any ? free_idx : ptr_q);

    // Pointer: zeroed by reset or flush, advanced after each replacement.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (fill_go && use_ptr) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_perm.sv
// Decides whether an access kind is allowed by a page's permission bits.
// Assumes the reserved access code is never allowed.
module tlb_perm
    import tlb_pkg::*;
(
    input  logic [1:0] acc,
    input  page_attr_t attr,
    output logic       allowed
);
    // Select the permission bit that the access kind needs.
    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  allowed = attr.rd;
            ACC_WRITE: allowed = attr.wr;
            ACC_EXEC:  allowed = attr.ex;
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_fa.sv
// Fully associative translation buffer: combinational lookup, one-cycle fill,
// one-cycle flush. Assumes 4 KiB pages (OFF_W offset bits pass through).
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [1:0]            lk_acc,
    output logic                  lk_hit,
    output logic                  lk_fault,
    output logic [PA_W-1:0]       lk_paddr,
    output logic                  lk_cacheable,
    output logic                  lk_wthru,
    input  logic                  fill_en,
    input  logic [VA_W-OFF_W-1:0] fill_vpn,
    input  logic [PA_W-OFF_W-1:0] fill_ppn,
    input  logic                  fill_rd,
    input  logic                  fill_wr,
    input  logic                  fill_ex,
    input  logic                  fill_cache,
    input  logic                  fill_wt,
    input  logic                  fill_present,
    input  logic                  flush
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid;
    logic [ENTRIES-1:0] fill_match;
    logic [IDX_W-1:0]   wr_idx;
    logic               fill_go;
    logic               any;
    logic               allowed;
    logic [PPN_W-1:0]   ppn;
    page_attr_t         attr;
    page_attr_t         wr_attr;

    assign fill_go = fill_en && fill_present && !flush;
    assign wr_attr = '{rd: fill_rd, wr: fill_wr, ex: fill_ex,
                       cache: fill_cache, wt: fill_wt};

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_cam (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(fill_go), .wr_idx(wr_idx), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
        .wr_attr(wr_attr), .lk_vpn(lk_vaddr[VA_W-1:OFF_W]),
        .valid(valid), .fill_match(fill_match),
        .lk_any(any), .lk_ppn(ppn), .lk_attr(attr)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_go(fill_go),
        .valid(valid), .fill_match(fill_match), .idx(wr_idx)
    );

    tlb_perm u_perm (.acc(lk_acc), .attr(attr), .allowed(allowed));

    // Output stage: suppress everything on a miss or during flush.
    always_comb begin
        lk_hit       = any && !flush;
        lk_fault     = lk_hit && !allowed;
        lk_paddr     = lk_hit ? {ppn, lk_vaddr[OFF_W-1:0]} : '0;
        lk_cacheable = lk_hit && attr.cache;
        lk_wthru     = lk_hit && attr.wt;
    end
endmodule

// File: rtl/tlb_fa_chk.sv
// Temporal checks on the translation buffer ports, bound to every tlb_fa.
module tlb_fa_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [VA_W-1:0]       lk_vaddr,
    input logic                  lk_hit,
    input logic                  lk_fault,
    input logic [PA_W-1:0]       lk_paddr,
    input logic                  lk_cacheable,
    input logic                  lk_wthru,
    input logic                  fill_en,
    input logic [VA_W-OFF_W-1:0] fill_vpn,
    input logic                  fill_present,
    input logic                  flush
);
    // R4
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R3
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0 && !lk_cacheable && !lk_wthru));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R10
    flush_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !lk_hit);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R7
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en && fill_present && !flush) && !flush &&
         lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |-> lk_hit);
endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_fault(lk_fault), .lk_paddr(lk_paddr), .lk_cacheable(lk_cacheable),
    .lk_wthru(lk_wthru), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_present(fill_present), .flush(flush)
);

// File: tb/tlb_fa_test.sv
`timescale 1ns/1ps
// Bench: vector table of lookups after a fixed setup, then directed cases.
module tlb_fa_test;
    localparam int ENTRIES = 16;
    localparam int VA_W = 32, PA_W = 32, OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W, PPN_W = PA_W - OFF_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [1:0] lk_acc = '0;
    logic lk_hit, lk_fault, lk_cacheable, lk_wthru;
    logic [PA_W-1:0] lk_paddr;
    logic fill_en = 0, fill_rd = 0, fill_wr = 0, fill_ex = 0;
    logic fill_cache = 0, fill_wt = 0, fill_present = 0, flush = 0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tlb_fa #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) uut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  acc;
        logic        hit;
        logic        fault;
        logic [31:0] pa;
        logic        c;
        logic        wt;
    } vec_t;

    // Setup: page 0x10 read-only cacheable write-back, page 0x20 read/write
    // cacheable write-through, page 0x30 execute-only uncacheable, page 0x40 absent.
    localparam vec_t VECS [10] = '{
        '{32'h0001_0123, 2'd0, 1'b1, 1'b0, 32'h00A1_0123, 1'b1, 1'b0},
        '{32'h0001_0FFF, 2'd1, 1'b1, 1'b1, 32'h00A1_0FFF, 1'b1, 1'b0},
        '{32'h0001_0000, 2'd2, 1'b1, 1'b1, 32'h00A1_0000, 1'b1, 1'b0},
        '{32'h0002_0456, 2'd1, 1'b1, 1'b0, 32'h00B2_0456, 1'b1, 1'b1},
        '{32'h0002_0456, 2'd2, 1'b1, 1'b1, 32'h00B2_0456, 1'b1, 1'b1},
        '{32'h0003_0789, 2'd2, 1'b1, 1'b0, 32'h00C3_0789, 1'b0, 1'b0},
        '{32'h0003_0789, 2'd0, 1'b1, 1'b1, 32'h00C3_0789, 1'b0, 1'b0},
        '{32'h0002_0000, 2'd3, 1'b1, 1'b1, 32'h00B2_0000, 1'b1, 1'b1},
        '{32'h0004_0000, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h0005_0ABC, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                           input logic [4:0] attr, input logic pres, input logic fl);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_present = pres; flush = fl;
        {fill_rd, fill_wr, fill_ex, fill_cache, fill_wt} = attr;
        @(negedge clk);
        fill_en = 1'b0; fill_present = 1'b0; flush = 1'b0;
    endtask

    task automatic probe(input string req, input vec_t e);
        @(negedge clk);
        lk_vaddr = e.va; lk_acc = e.acc;
        #1;
        checks++;
        if ({lk_hit, lk_fault, lk_paddr, lk_cacheable, lk_wthru} !==
            {e.hit, e.fault, e.pa, e.c, e.wt}) begin
            errors++;
            $display("FAIL %s va=%h: got hit=%b fault=%b pa=%h c=%b wt=%b exp hit=%b fault=%b pa=%h c=%b wt=%b",
                     req, e.va, lk_hit, lk_fault, lk_paddr, lk_cacheable, lk_wthru,
                     e.hit, e.fault, e.pa, e.c, e.wt);
        end
    endtask

    function automatic vec_t hitv(input logic [19:0] v, input logic [19:0] p);
        return '{{v, 12'h345}, 2'd0, 1'b1, 1'b0, {p, 12'h345}, 1'b1, 1'b0};
    endfunction
    function automatic vec_t missv(input logic [19:0] v);
        return '{{v, 12'h345}, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        probe("R1", missv(20'h00010));
        probe("R1", missv(20'h00000));

        do_fill(20'h00010, 20'h00A10, 5'b10010, 1'b1, 1'b0);
        do_fill(20'h00020, 20'h00B20, 5'b11011, 1'b1, 1'b0);
        do_fill(20'h00030, 20'h00C30, 5'b00100, 1'b1, 1'b0);
        do_fill(20'h00040, 20'h00D40, 5'b11111, 1'b0, 1'b0); // R6 absent page
        // R2 R3 R4 R5 R6 vector walk
        for (int i = 0; i < 10; i++)
            probe(i == 8 ? "R6" : (VECS[i].hit ? (VECS[i].fault ? "R4" : "R2/R5") : "R3"), VECS[i]);

        // R9: refill held page in place with new mapping
        do_fill(20'h00020, 20'h0DD20, 5'b10010, 1'b1, 1'b0);
        probe("R9", hitv(20'h00020, 20'h0DD20));
        probe("R9", hitv(20'h00010, 20'h00A10));

        // R10: hit suppressed while flush is high
        @(negedge clk);
        flush = 1'b1; lk_vaddr = 32'h0001_0345; lk_acc = 2'd0;
        #1; checks++;
        if (lk_hit !== 1'b0) begin
            errors++; $display("FAIL R10 hit during flush got=%b exp=0", lk_hit);
        end
        @(negedge clk); flush = 1'b0;
        probe("R10", missv(20'h00010));
        probe("R10", missv(20'h00030));
        // R10: fill in a flush cycle dropped
        do_fill(20'h00077, 20'h00177, 5'b10010, 1'b1, 1'b1);
        probe("R10", missv(20'h00077));

        // R7: fill all slots from empty
        for (int i = 0; i < ENTRIES; i++)
            do_fill(20'h00100 + 20'(i), 20'h00500 + 20'(i), 5'b10010, 1'b1, 1'b0);
        for (int i = 0; i < ENTRIES; i++)
            probe("R7", hitv(20'h00100 + 20'(i), 20'h00500 + 20'(i)));

        // R8: replacement order from pointer 0
        do_fill(20'h00200, 20'h00600, 5'b10010, 1'b1, 1'b0);
        probe("R8", missv(20'h00100));
        probe("R8", hitv(20'h00101, 20'h00501));
        probe("R8", hitv(20'h00200, 20'h00600));
        // R9: refill between replacements leaves pointer alone
        do_fill(20'h00105, 20'h00705, 5'b10010, 1'b1, 1'b0);
        probe("R9", hitv(20'h00105, 20'h00705));
        do_fill(20'h00201, 20'h00601, 5'b10010, 1'b1, 1'b0);
        probe("R8", missv(20'h00101));
        probe("R8", hitv(20'h00102, 20'h00502));
        // R8: wrap after last slot
        for (int i = 2; i < ENTRIES; i++)
            do_fill(20'h00300 + 20'(i), 20'h00800 + 20'(i), 5'b10010, 1'b1, 1'b0);
        do_fill(20'h00400, 20'h00900, 5'b10010, 1'b1, 1'b0);
        probe("R8", missv(20'h00200));
        probe("R8", hitv(20'h00201, 20'h00601));

        // R1: reset clears contents
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        probe("R1", missv(20'h00201));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule